// File: doc/BRIEF.md
# Balance Status and Command Readback Serializer

This block produces the 16-bit words that a cell-balancing controller returns on its serial port. There are two kinds of word. A status word reports per-balancer gate-drive health and three fault-free flags. A readback word echoes the latched 12-bit balance command. Each word is a 12-bit message followed by a 4-bit check field. The check field is the CRC-4 remainder for the generator x^4 + x + 1, bit-inverted, so a line stuck at zero can never form a valid word.

The control logic around the block pulses a load strobe when a read command byte has been received. It then pulses a shift strobe once per falling serial-clock edge. The block presents its own word most significant bit first. After the sixteenth shift it passes the serial data coming from the next device up the stack straight to its output. In a chain, the host therefore receives the bottom device's word first, then each device above in turn. The balancer activity mask and the raw fault indications are inputs. Whether a status flag may read 1 depends on which balancers are executing.

Top module: `rdbk_serializer`

## Requirements
- R1: A status word places gate-drive-OK for balancer 1 at word bit 15 down to balancer 6 at bit 10. Cells-not-overvoltage is at bit 9, secondary-not-overvoltage at bit 8 and temperature-OK at bit 7. Bits 6..4 are 0. With balancers 1 and 4 executing and no fault, the message is 100100111000.
- R2: Gate-drive-OK bit n equals the raw indication of balancer n (gateOkRaw[n-1]) ANDed with that balancer executing (balActive[n-1]); an idle balancer reads 0.
- R3: The three fault-free flags equal their raw inputs only while at least one balancer is executing; with balActive all zero they read 0.
- R4: Word bits 3..0 are the bitwise inverse of the remainder of (message · x^4) divided by x^4 + x + 1; an all-zero message yields the word 0x000F.
- R5: A command-readback load produces {cmdMsg, inverted CRC-4 of cmdMsg}.
- R6: After a load, word bit 15 appears on serOut in the next cycle. Each accepted shift strobe advances one bit, most significant first. Without a strobe the output holds.
- R7: After 16 shifts of its own word, serOut equals chainIn in the same cycle until the next load.
- R8: From reset until the first load, serOut is 0 and shift strobes have no effect.
- R9: When both load strobes arrive in one cycle, the status word is loaded.
- R10: A load restarts the output at bit 15 of the new word, even mid-word; a shift strobe in the same cycle as a load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadStatus | input | 1 | Read-status command completed; load a status word |
| loadCmd | input | 1 | Readback command completed; load a readback word |
| shiftStb | input | 1 | One pulse per falling serial-clock edge |
| balActive | input | 6 | Balancers currently executing, bit 0 = balancer 1 |
| gateOkRaw | input | 6 | Raw gate-drive-sufficient indications, bit 0 = balancer 1 |
| cellsOkRaw | input | 1 | Raw indication that no cell is overvoltage |
| secOkRaw | input | 1 | Raw indication that the secondary is not overvoltage |
| tempOkRaw | input | 1 | Raw indication that die temperature is acceptable |
| cmdMsg | input | 12 | Latched 12-bit balance command message |
| chainIn | input | 1 | Serial data from the next device up the stack |
| serOut | output | 1 | Serial data toward the host |

## Verification
Some properties are checked on every cycle. The output stays quiet before the first load and holds between strobes. It passes chainIn through once sixteen shifts have completed. The first bit after each kind of load matches the selected message's top bit. Only the bench's scenarios show the complete status layout, the inverted check field for particular messages, and the load priority. They also show the restart of a word mid-stream and the forwarded bits that follow. The bench shifts entire words out and compares them bit by bit with words it computes by polynomial long division.

// File: rtl/rdbk_ser_pkg.sv
package rdbk_ser_pkg;

  localparam int CRC_W = 4;
  // generator x^4 + x + 1 without its leading term
  localparam logic [CRC_W-1:0] CRC_POLY = 4'b0011;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_OWN,
    PH_FWD
  } serPhase_t;

  typedef struct packed {
    logic loadStat;
    logic loadCmd;
    logic shift;
    logic fwdSel;
  } serStrobes_t;

endpackage

// File: rtl/rdbk_ser_ctrl.sv
module rdbk_ser_ctrl
  import rdbk_ser_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadStatus,
  input  logic        loadCmd,
  input  logic        shiftStb,
  output serStrobes_t strb
);

  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(WORD_W - 1);

  serPhase_t phase;
  logic [CW-1:0] bitCnt;
  logic anyLoad;

  assign anyLoad = loadStatus | loadCmd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
    end else if (anyLoad) begin
      phase  <= PH_OWN;
      bitCnt <= '0;
    end else if (shiftStb && phase == PH_OWN) begin
      if (bitCnt == LAST_BIT) begin
        phase  <= PH_FWD;
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.loadStat = loadStatus;
    strb.loadCmd  = loadCmd & ~loadStatus;
    strb.shift    = shiftStb & ~anyLoad & (phase == PH_OWN);
    strb.fwdSel   = (phase == PH_FWD);
  end

endmodule

// File: rtl/rdbk_ser_datapath.sv
module rdbk_ser_datapath
  import rdbk_ser_pkg::*;
#(
  parameter int NUM_BAL = 6,
  parameter int MSG_W   = 12,
  parameter int WORD_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  serStrobes_t        strb,
  input  logic [NUM_BAL-1:0] balActive,
  input  logic [NUM_BAL-1:0] gateOkRaw,
  input  logic               cellsOkRaw,
  input  logic               secOkRaw,
  input  logic               tempOkRaw,
  input  logic [MSG_W-1:0]   cmdMsg,
  input  logic               chainIn,
  output logic               serOut
);

  localparam int FLAG_TOP = MSG_W - NUM_BAL - 1;
  localparam int PAD_W    = MSG_W - NUM_BAL - 3;
  localparam logic [WORD_W-1:0] RESET_WORD = {{MSG_W{1'b0}}, {CRC_W{1'b1}}};

  function automatic logic [CRC_W-1:0] crcRem(input logic [MSG_W-1:0] m);
    logic [CRC_W-1:0] r;
    logic fb;
    r = '0;
    for (int i = MSG_W - 1; i >= 0; i--) begin
      fb = m[i] ^ r[CRC_W-1];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return r;
  endfunction

  logic [MSG_W-1:0]  statMsg;
  logic [MSG_W-1:0]  selMsg;
  logic [WORD_W-1:0] nextWord;
  logic [WORD_W-1:0] shReg;
  logic              anyActive;

  assign anyActive = |balActive;

  // per-balancer gate-drive bits, balancer 1 in the message MSB
  for (genvar g = 0; g < NUM_BAL; g++) begin : g_gate
    assign statMsg[MSG_W-1-g] = gateOkRaw[g] & balActive[g];
  end

  assign statMsg[FLAG_TOP]   = cellsOkRaw & anyActive;
  assign statMsg[FLAG_TOP-1] = secOkRaw & anyActive;
  assign statMsg[FLAG_TOP-2] = tempOkRaw & anyActive;

  if (PAD_W > 0) begin : g_pad
    assign statMsg[PAD_W-1:0] = '0;
  end

  assign selMsg   = strb.loadStat ? statMsg : cmdMsg;
  assign nextWord = {selMsg, ~crcRem(selMsg)};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= RESET_WORD;
    end else if (strb.loadStat || strb.loadCmd) begin
      shReg <= nextWord;
    end else if (strb.shift) begin
      shReg <= {shReg[WORD_W-2:0], 1'b0};
    end
  end

  assign serOut = strb.fwdSel ? chainIn : shReg[WORD_W-1];

endmodule

// File: rtl/rdbk_serializer.sv
module rdbk_serializer
  import rdbk_ser_pkg::*;
#(
  parameter int NUM_BAL = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadStatus,
  input  logic                 loadCmd,
  input  logic                 shiftStb,
  input  logic [NUM_BAL-1:0]   balActive,
  input  logic [NUM_BAL-1:0]   gateOkRaw,
  input  logic                 cellsOkRaw,
  input  logic                 secOkRaw,
  input  logic                 tempOkRaw,
  input  logic [2*NUM_BAL-1:0] cmdMsg,
  input  logic                 chainIn,
  output logic                 serOut
);

  localparam int MSG_W  = 2 * NUM_BAL;
  localparam int WORD_W = MSG_W + CRC_W;

  serStrobes_t strb;

  rdbk_ser_ctrl #(
    .WORD_W(WORD_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .loadStatus(loadStatus),
    .loadCmd   (loadCmd),
    .shiftStb  (shiftStb),
    .strb      (strb)
  );

  rdbk_ser_datapath #(
    .NUM_BAL(NUM_BAL),
    .MSG_W  (MSG_W),
    .WORD_W (WORD_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .balActive (balActive),
    .gateOkRaw (gateOkRaw),
    .cellsOkRaw(cellsOkRaw),
    .secOkRaw  (secOkRaw),
    .tempOkRaw (tempOkRaw),
    .cmdMsg    (cmdMsg),
    .chainIn   (chainIn),
    .serOut    (serOut)
  );

endmodule

// File: rtl/rdbk_serializer_chk.sv
module rdbk_serializer_chk #(
  parameter int WORD_W = 16
) (
  input logic clk,
  input logic rstN,
  input logic loadStatus,
  input logic loadCmd,
  input logic shiftStb,
  input logic chainIn,
  input logic serOut,
  input logic cmdMsb,
  input logic statMsb
);

  localparam int CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] FULL = CW'(WORD_W);

  logic [CW-1:0] seenShifts;
  logic          seenLoad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenShifts <= '0;
      seenLoad   <= 1'b0;
    end else if (loadStatus || loadCmd) begin
      seenShifts <= '0;
      seenLoad   <= 1'b1;
    end else if (shiftStb && seenShifts != FULL) begin
      seenShifts <= seenShifts + 1'b1;
    end
  end

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !seenLoad |-> serOut == 1'b0);

  p_forward_r7: assert property (@(posedge clk) disable iff (!rstN)
    (seenLoad && seenShifts == FULL) |-> serOut == chainIn);

  p_cmd_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    (loadCmd && !loadStatus) |=> serOut == $past(cmdMsb));

  p_stat_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    loadStatus |=> serOut == $past(statMsb));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (seenLoad && seenShifts < FULL && !shiftStb && !loadStatus && !loadCmd)
      |=> $stable(serOut));

endmodule

bind rdbk_serializer rdbk_serializer_chk #(
  .WORD_W(WORD_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .loadStatus(loadStatus),
  .loadCmd   (loadCmd),
  .shiftStb  (shiftStb),
  .chainIn   (chainIn),
  .serOut    (serOut),
  .cmdMsb    (cmdMsg[MSG_W-1]),
  .statMsb   (gateOkRaw[0] & balActive[0])
);

// File: tb/rdbk_serializer_tb_top.sv
module rdbk_serializer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadStatus = 1'b0;
  logic          loadCmd = 1'b0;
  logic          shiftStb = 1'b0;
  logic [NB-1:0] balActive = '0;
  logic [NB-1:0] gateOkRaw = '0;
  logic          cellsOkRaw = 1'b0;
  logic          secOkRaw = 1'b0;
  logic          tempOkRaw = 1'b0;
  logic [11:0]   cmdMsg = '0;
  logic          chainIn = 1'b0;
  logic          serOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic  expBits[$];
  string expTags[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rdbk_serializer #(.NUM_BAL(NB)) dut_i (
    .clk(clk), .rstN(rstN), .loadStatus(loadStatus), .loadCmd(loadCmd),
    .shiftStb(shiftStb), .balActive(balActive), .gateOkRaw(gateOkRaw),
    .cellsOkRaw(cellsOkRaw), .secOkRaw(secOkRaw), .tempOkRaw(tempOkRaw),
    .cmdMsg(cmdMsg), .chainIn(chainIn), .serOut(serOut)
  );

  // reference word by polynomial long division (R4)
  function automatic logic [15:0] refWord(input logic [11:0] m);
    logic [15:0] r;
    r = {m, 4'b0000};
    for (int b = 15; b >= 4; b--)
      if (r[b]) r = r ^ (16'(5'b10011) << (b - 4));
    return {m, ~r[3:0]};
  endfunction

  // reference status message from R1..R3
  function automatic logic [11:0] statusRef(input logic [NB-1:0] act,
      input logic [NB-1:0] gate, input logic c, input logic s, input logic t);
    logic [11:0] m;
    m = '0;
    for (int i = 0; i < NB; i++) m[11-i] = gate[i] & act[i];
    m[5] = c & (|act);
    m[4] = s & (|act);
    m[3] = t & (|act);
    return m;
  endfunction

  task automatic check1(input logic act, input logic exp, input string tag, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expected bit per accepted shift strobe
  initial begin
    logic  b;
    string t;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (shiftStb && !loadStatus && !loadCmd && expBits.size() > 0) begin
        b = expBits.pop_front();
        t = expTags.pop_front();
        total++;
        if (serOut !== b) begin
          bad++;
          $display("FAIL %s serial bit actual=%b expected=%b", t, serOut, b);
        end
      end
    end
  end

  task automatic doLoad(input logic s, input logic c, input logic withShift);
    @(negedge clk);
    loadStatus = s;
    loadCmd = c;
    shiftStb = withShift;
    @(negedge clk);
    loadStatus = 1'b0;
    loadCmd = 1'b0;
    shiftStb = 1'b0;
  endtask

  // driver: pushes expected bits and issues shifts for the first n bits
  task automatic shiftOwn(input logic [15:0] w, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      expBits.push_back(w[15-i]);
      expTags.push_back(tag);
      shiftStb = 1'b1;
      @(negedge clk);
    end
    shiftStb = 1'b0;
  endtask

  task automatic shiftFwd(input logic [7:0] pat, input int n);
    for (int i = 0; i < n; i++) begin
      chainIn = pat[i];
      expBits.push_back(pat[i]);
      expTags.push_back("R7");
      shiftStb = 1'b1;
      @(negedge clk);
    end
    shiftStb = 1'b0;
    chainIn = 1'b0;
  endtask

  task automatic setStatus(input logic [NB-1:0] act, input logic [NB-1:0] gate,
      input logic c, input logic s, input logic t);
    balActive = act;
    gateOkRaw = gate;
    cellsOkRaw = c;
    secOkRaw = s;
    tempOkRaw = t;
  endtask

  initial begin
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R8: quiet before any load, strobes ignored
    check1(serOut, 1'b0, "R8", "after reset");
    chainIn = 1'b1;
    for (int i = 0; i < 3; i++) begin
      shiftStb = 1'b1;
      @(negedge clk);
      #1;
      check1(serOut, 1'b0, "R8", "shift before load");
    end
    shiftStb = 1'b0;
    chainIn = 1'b0;

    // R3 and R4: no balancer executing -> 0x000F, then forwarded data
    setStatus('0, '1, 1'b1, 1'b1, 1'b1);
    doLoad(1'b1, 1'b0, 1'b0);
    check1(serOut, 1'b0, "R6", "first bit after load");
    shiftOwn(16'h000F, 16, "R3/R4");
    shiftFwd(8'b1101_0110, 8);

    // R1: balancers 1 and 4 fault-free
    setStatus(6'b001001, '1, 1'b1, 1'b1, 1'b1);
    doLoad(1'b1, 1'b0, 1'b0);
    w = refWord(12'b100100111000);
    check1(serOut, w[15], "R6", "first bit status");
    repeat (3) @(negedge clk);
    check1(serOut, w[15], "R6", "hold without strobe");
    shiftOwn(w, 16, "R1");

    // R2: mixed gate-drive indications, one flag bad
    setStatus(6'b111111, 6'b101010, 1'b1, 1'b0, 1'b1);
    doLoad(1'b1, 1'b0, 1'b0);
    shiftOwn(refWord(statusRef(6'b111111, 6'b101010, 1'b1, 1'b0, 1'b1)), 16, "R2");
    setStatus(6'b110100, 6'b011111, 1'b0, 1'b1, 1'b1);
    doLoad(1'b1, 1'b0, 1'b0);
    shiftOwn(refWord(statusRef(6'b110100, 6'b011111, 1'b0, 1'b1, 1'b1)), 16, "R2");

    // R5: command readback
    cmdMsg = 12'hA5C;
    doLoad(1'b0, 1'b1, 1'b0);
    shiftOwn(refWord(12'hA5C), 16, "R5");
    cmdMsg = 12'h000;
    doLoad(1'b0, 1'b1, 1'b0);
    shiftOwn(16'h000F, 16, "R4");
    cmdMsg = 12'hFFF;
    doLoad(1'b0, 1'b1, 1'b0);
    shiftOwn(refWord(12'hFFF), 16, "R5");
    shiftFwd(8'b0011_1001, 8);

    // R9: both loads together -> status
    setStatus(6'b000001, '1, 1'b1, 1'b1, 1'b0);
    cmdMsg = 12'h0F0;
    doLoad(1'b1, 1'b1, 1'b0);
    shiftOwn(refWord(statusRef(6'b000001, '1, 1'b1, 1'b1, 1'b0)), 16, "R9");

    // R10: restart mid-word, with a shift in the load cycle
    setStatus(6'b000011, '1, 1'b1, 1'b1, 1'b1);
    doLoad(1'b1, 1'b0, 1'b0);
    shiftOwn(refWord(statusRef(6'b000011, '1, 1'b1, 1'b1, 1'b1)), 5, "R10");
    cmdMsg = 12'h6B3;
    doLoad(1'b0, 1'b1, 1'b1);
    w = refWord(12'h6B3);
    check1(serOut, w[15], "R10", "first bit after restart");
    shiftOwn(w, 16, "R10");
    shiftFwd(8'b1010_0101, 4);

    repeat (2) @(negedge clk);
    check1(logic'(expBits.size() == 0), 1'b1, "R6", "all expected bits consumed");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R6 watchdog actual=running expected=finished");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule